// File: doc/BRIEF.md
# Sector-Alignment Request Planner

This block sits between a byte-granular DMA engine and a sector-oriented storage back end. It accepts a transfer request that gives a byte offset on the disk, a byte length and a direction. It turns that request into a plan that the back end can act on: an aligned start sector, a whole number of sectors, the number of leading bytes that lie in front of the caller's data inside the first sector, and the number of pad bytes that follow the data inside the last sector. Sectors are 512 bytes.

A read never needs extra traffic. The head bytes and the tail pad are simply fetched and thrown away. A write that starts or ends part-way through a sector must first fetch the old contents of that edge sector, so that the bytes outside the caller's range survive a read-modify-write. For such writes the planner issues one or two pre-read commands on a valid/ready port. It waits for a completion pulse after each command, and only then announces the plan. The planner moves no data itself.

Top module: `sect_align_planner`

## Requirements
- R1: After reset, req_ready is 1 and both pre_valid and plan_valid are 0.
- R2: plan_sector equals the request offset shifted right by 9. For a nonzero length, plan_head equals the offset modulo 512.
- R3: For a nonzero length, plan_pad equals (512 - ((offset + length) mod 512)) mod 512.
- R4: plan_count equals (plan_head + length + plan_pad) / 512, which is the number of whole sectors covered.
- R5: A read request never raises pre_valid. Its plan_valid rises in the cycle that directly follows the acceptance edge.
- R6: A write of nonzero length whose offset is not a multiple of 512 first issues a pre-read for sector offset >> 9.
- R7: A write of nonzero length whose end (offset + length) is not a multiple of 512, and whose end lies in a different sector from its start, issues a pre-read for sector (offset + length) >> 9. When a head pre-read is also needed, this one is issued only after the head pre-read's completion.
- R8: When a write both starts and ends inside one and the same sector, exactly one pre-read is issued.
- R9: A zero-length request issues no pre-read. Its plan_valid rises in the cycle that follows acceptance, with plan_head, plan_pad and plan_count all 0.
- R10: req_ready is 0 from acceptance until the plan_valid cycle has passed. While pre_valid waits for pre_ready, pre_sector holds still. A pre_done pulse that arrives before its command has been accepted is ignored.
- R11: plan_valid is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Planner idle and able to take a request |
| req_offset | input | OFF_W | Byte offset of the transfer on the disk |
| req_len | input | LEN_W | Byte length of the transfer |
| req_write | input | 1 | 1 for a write, 0 for a read |
| pre_valid | output | 1 | Edge-sector pre-read command present |
| pre_ready | input | 1 | Pre-read command accepted |
| pre_sector | output | OFF_W-9 | Sector that the pre-read must fetch |
| pre_done | input | 1 | Pulse: the accepted pre-read has finished |
| plan_valid | output | 1 | One-cycle pulse: plan outputs are valid |
| plan_head | output | 9 | Bytes before the data in the first sector |
| plan_pad | output | 9 | Bytes after the data in the last sector |
| plan_sector | output | OFF_W-9 | Aligned start sector |
| plan_count | output | LEN_W-7 | Number of sectors in the aligned request |

## Verification
The bench keeps the default widths: a 32-bit offset and a 20-bit length. With these widths, a random length can span more than two thousand sectors, so the upper bits of plan_count are exercised. Random offsets are kept below 2^31 so that the end address never wraps. The 9-bit head and pad fields reach both extremes, 0 and 511, through directed cases: a head in the last byte of a sector, and a transfer that ends one byte past a boundary. The pre-read responder stalls pre_ready and pre_done for random intervals and injects early completion pulses, which covers the handshake ordering.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Sector geometry: 512-byte sectors
    localparam int SAP_LG2  = 9;
    localparam int SAP_SECT = 1 << SAP_LG2;

    typedef logic [SAP_LG2-1:0] sect_ofs_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HD_CMD,
        ST_HD_WAIT,
        ST_TL_CMD,
        ST_TL_WAIT,
        ST_FINISH
    } sap_state_e;

    // Which edge sectors need a pre-read before the write may go out
    typedef struct packed {
        logic head;
        logic tail;
    } pre_need_t;

    // Bytes needed to fill the last sector up to its boundary
    function automatic sect_ofs_t sap_pad(input sect_ofs_t tail_ofs);
        logic [SAP_LG2:0] full;
        full = (SAP_LG2+1)'(SAP_SECT) - {1'b0, tail_ofs};
        return full[SAP_LG2-1:0];
    endfunction

endpackage

// File: rtl/sap_calc.sv
module sap_calc
    import sap_pkg::*;
#(
    parameter int OFF_W = 32,
    parameter int LEN_W = 20
) (
    input  logic [OFF_W-1:0]               off,
    input  logic [LEN_W-1:0]               len,
    input  logic                           wr,
    output sect_ofs_t                      head,
    output sect_ofs_t                      pad,
    output logic [OFF_W-SAP_LG2-1:0]       start_sec,
    output logic [OFF_W-SAP_LG2-1:0]       last_sec,
    output logic [LEN_W-SAP_LG2+1:0]       count,
    output pre_need_t                      need
);
    localparam int END_W = OFF_W + 1;
    localparam int SUM_W = LEN_W + 2;

    logic [END_W-1:0] end_addr;
    logic             zero_len;
    sect_ofs_t        head_raw;
    sect_ofs_t        tail_raw;
    logic             same_sec;
    logic [SUM_W-1:0] span;

    always_comb begin
        end_addr  = {1'b0, off} + END_W'(len);
        zero_len  = (len == '0);
        head_raw  = off[SAP_LG2-1:0];
        tail_raw  = end_addr[SAP_LG2-1:0];
        same_sec  = (end_addr[END_W-1:SAP_LG2] == {1'b0, off[OFF_W-1:SAP_LG2]});

        head      = zero_len ? '0 : head_raw;
        pad       = zero_len ? '0 : sap_pad(tail_raw);
        start_sec = off[OFF_W-1:SAP_LG2];
        last_sec  = end_addr[OFF_W-1:SAP_LG2];

        // head + len + pad is a whole number of sectors by construction
        span      = SUM_W'(head) + SUM_W'(len) + SUM_W'(pad);
        count     = zero_len ? '0 : span[SUM_W-1:SAP_LG2];

        need.head = wr && !zero_len && (head_raw != '0);
        need.tail = wr && !zero_len && (tail_raw != '0) &&
                    !((head_raw != '0) && same_sec);
    end

endmodule

// File: rtl/sap_ctrl.sv
module sap_ctrl
    import sap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  pre_need_t need,
    input  logic      pre_ready,
    input  logic      pre_done,
    output logic      req_ready,
    output logic      accept,
    output logic      pre_valid,
    output logic      pre_is_tail,
    output logic      plan_valid
);
    sap_state_e state_q, state_d;
    logic       tail_q;

    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        accept      = req_ready && req_valid;
        pre_valid   = (state_q == ST_HD_CMD) || (state_q == ST_TL_CMD);
        pre_is_tail = (state_q == ST_TL_CMD);
        plan_valid  = (state_q == ST_FINISH);

        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (need.head)      state_d = ST_HD_CMD;
                    else if (need.tail) state_d = ST_TL_CMD;
                    else                state_d = ST_FINISH;
                end
            end
            ST_HD_CMD:  if (pre_ready) state_d = ST_HD_WAIT;
            ST_HD_WAIT: if (pre_done)  state_d = tail_q ? ST_TL_CMD : ST_FINISH;
            ST_TL_CMD:  if (pre_ready) state_d = ST_TL_WAIT;
            ST_TL_WAIT: if (pre_done)  state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) tail_q <= need.tail;
        end
    end

endmodule

// File: rtl/sect_align_planner.sv
module sect_align_planner
    import sap_pkg::*;
#(
    parameter int OFF_W = 32,
    parameter int LEN_W = 20
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [OFF_W-1:0]               req_offset,
    input  logic [LEN_W-1:0]               req_len,
    input  logic                           req_write,
    output logic                           pre_valid,
    input  logic                           pre_ready,
    output logic [OFF_W-SAP_LG2-1:0]       pre_sector,
    input  logic                           pre_done,
    output logic                           plan_valid,
    output logic [SAP_LG2-1:0]             plan_head,
    output logic [SAP_LG2-1:0]             plan_pad,
    output logic [OFF_W-SAP_LG2-1:0]       plan_sector,
    output logic [LEN_W-SAP_LG2+1:0]       plan_count
);
    localparam int SEC_W = OFF_W - SAP_LG2;
    localparam int CNT_W = LEN_W - SAP_LG2 + 2;

    sect_ofs_t        c_head, c_pad;
    logic [SEC_W-1:0] c_start, c_last;
    logic [CNT_W-1:0] c_count;
    pre_need_t        c_need;
    logic             accept;
    logic             pre_is_tail;

    sect_ofs_t        head_q, pad_q;
    logic [SEC_W-1:0] start_q, last_q;
    logic [CNT_W-1:0] count_q;

    sap_calc #(.OFF_W(OFF_W), .LEN_W(LEN_W)) calc_i (
        .off       (req_offset),
        .len       (req_len),
        .wr        (req_write),
        .head      (c_head),
        .pad       (c_pad),
        .start_sec (c_start),
        .last_sec  (c_last),
        .count     (c_count),
        .need      (c_need)
    );

    sap_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .need        (c_need),
        .pre_ready   (pre_ready),
        .pre_done    (pre_done),
        .req_ready   (req_ready),
        .accept      (accept),
        .pre_valid   (pre_valid),
        .pre_is_tail (pre_is_tail),
        .plan_valid  (plan_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            pad_q   <= '0;
            start_q <= '0;
            last_q  <= '0;
            count_q <= '0;
        end else if (accept) begin
            head_q  <= c_head;
            pad_q   <= c_pad;
            start_q <= c_start;
            last_q  <= c_last;
            count_q <= c_count;
        end
    end

    assign pre_sector  = pre_is_tail ? last_q : start_q;
    assign plan_head   = head_q;
    assign plan_pad    = pad_q;
    assign plan_sector = start_q;
    assign plan_count  = count_q;

endmodule

// File: rtl/sap_checker.sv
module sap_checker
    import sap_pkg::*;
#(
    parameter int OFF_W = 32,
    parameter int LEN_W = 20
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [OFF_W-1:0]         req_offset,
    input logic [LEN_W-1:0]         req_len,
    input logic                     req_write,
    input logic                     pre_valid,
    input logic                     pre_ready,
    input logic [OFF_W-SAP_LG2-1:0] pre_sector,
    input logic                     plan_valid,
    input logic [SAP_LG2-1:0]       plan_head,
    input logic [SAP_LG2-1:0]       plan_pad,
    input logic [LEN_W-SAP_LG2+1:0] plan_count
);
    localparam int SUM_W = LEN_W + 2;

    logic             acc;
    logic [LEN_W-1:0] len_q;
    logic [SUM_W-1:0] span_w;
    logic [SUM_W-1:0] cnt_bytes;

    assign acc       = req_valid && req_ready;
    assign span_w    = SUM_W'(plan_head) + SUM_W'(len_q) + SUM_W'(plan_pad);
    assign cnt_bytes = {plan_count, {SAP_LG2{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst)      len_q <= '0;
        else if (acc) len_q <= req_len;
    end

    // R1: no pre-read or plan is ever announced while the planner is idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !pre_valid && !plan_valid);

    // R4: the sector count covers head, data and pad exactly
    a_r4_span: assert property (@(posedge clk) disable iff (rst)
        plan_valid |-> cnt_bytes == span_w);

    // R5: a read goes straight to its plan
    a_r5_read_direct: assert property (@(posedge clk) disable iff (rst)
        acc && !req_write |=> plan_valid && !pre_valid);

    // R6: an unaligned write head is pre-read first
    a_r6_head_first: assert property (@(posedge clk) disable iff (rst)
        acc && req_write && (req_len != '0) && (req_offset[SAP_LG2-1:0] != '0)
        |=> pre_valid && pre_sector == $past(req_offset[OFF_W-1:SAP_LG2]));

    // R9: a zero-length request finishes immediately with an empty plan
    a_r9_zero_len: assert property (@(posedge clk) disable iff (rst)
        acc && (req_len == '0) |=> plan_valid && plan_count == '0);

    // R10: a pending pre-read keeps its sector until taken
    a_r10_pre_hold: assert property (@(posedge clk) disable iff (rst)
        pre_valid && !pre_ready |=> pre_valid && $stable(pre_sector));

    // R11: the plan pulse lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        plan_valid |=> !plan_valid);

endmodule

bind sect_align_planner sap_checker #(.OFF_W(OFF_W), .LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_offset (req_offset),
    .req_len    (req_len),
    .req_write  (req_write),
    .pre_valid  (pre_valid),
    .pre_ready  (pre_ready),
    .pre_sector (pre_sector),
    .plan_valid (plan_valid),
    .plan_head  (plan_head),
    .plan_pad   (plan_pad),
    .plan_count (plan_count)
);

// File: tb/sect_align_planner_tb.sv
`timescale 1ns/1ps
module sect_align_planner_tb_top;
    localparam int OFF_W = 32;
    localparam int LEN_W = 20;
    localparam int SEC_W = OFF_W - 9;
    localparam int CNT_W = LEN_W - 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [OFF_W-1:0] req_offset = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_write = 1'b0;
    logic             pre_valid;
    logic             pre_ready = 1'b0;
    logic [SEC_W-1:0] pre_sector;
    logic             pre_done = 1'b0;
    logic             plan_valid;
    logic [8:0]       plan_head;
    logic [8:0]       plan_pad;
    logic [SEC_W-1:0] plan_sector;
    logic [CNT_W-1:0] plan_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sect_align_planner #(.OFF_W(OFF_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_len(req_len), .req_write(req_write),
        .pre_valid(pre_valid), .pre_ready(pre_ready), .pre_sector(pre_sector),
        .pre_done(pre_done),
        .plan_valid(plan_valid), .plan_head(plan_head), .plan_pad(plan_pad),
        .plan_sector(plan_sector), .plan_count(plan_count)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic run_req(input longint off, input longint len, input bit wr);
        longint endv, e_head, e_pad, e_sec, e_cnt, e_s[2];
        int     e_npre, npre, wait_cyc;
        bit     got, h, t, same;
        endv   = off + len;
        e_head = (len == 0) ? 0 : (off % 512);
        e_pad  = (len == 0) ? 0 : ((512 - (endv % 512)) % 512);
        e_sec  = off / 512;
        e_cnt  = (len == 0) ? 0 : ((endv + 511) / 512 - off / 512);
        h      = wr && len != 0 && (off % 512) != 0;
        t      = wr && len != 0 && (endv % 512) != 0;
        same   = (endv / 512) == (off / 512);
        e_npre = int'(h) + int'(t) - int'(h && t && same);
        e_s[0] = h ? off / 512 : endv / 512;
        e_s[1] = endv / 512;

        @(negedge clk);
        chk("R10 ready before request", longint'(req_ready), 1);
        req_offset = OFF_W'(off);
        req_len    = LEN_W'(len);
        req_write  = wr;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;

        npre = 0; got = 0; wait_cyc = 0;
        while (!got && wait_cyc < 300) begin
            if (plan_valid) begin
                got = 1;
                chk("R10 busy during plan", longint'(req_ready), 0);
                chk("R2 head", longint'(plan_head), e_head);
                chk("R2 sector", longint'(plan_sector), e_sec);
                chk("R3 pad", longint'(plan_pad), e_pad);
                chk("R4 count", longint'(plan_count), e_cnt);
                if (len == 0) chk("R9 pre-reads on empty", npre, 0);
                else if (!wr) chk("R5 read pre-reads", npre, 0);
                else if (h && t && same) chk("R8 single pre-read", npre, 1);
                else chk("R7 pre-read count", npre, e_npre);
                if (!wr || len == 0) chk("R5 R9 latency", wait_cyc, 0);
                @(negedge clk);
                chk("R11 pulse ends", longint'(plan_valid), 0);
                chk("R10 ready after plan", longint'(req_ready), 1);
            end else if (pre_valid) begin
                if (npre < 2) begin
                    if (npre == 0 && h) chk("R6 head sector", longint'(pre_sector), e_s[0]);
                    else chk("R7 tail sector", longint'(pre_sector), e_s[npre]);
                end
                npre++;
                chk("R10 busy during pre-read", longint'(req_ready), 0);
                // early completion must be ignored
                pre_done = 1'b1;
                @(negedge clk);
                pre_done = 1'b0;
                chk("R10 early done ignored", longint'(pre_valid), 1);
                repeat ($urandom_range(2)) @(negedge clk);
                pre_ready = 1'b1;
                @(negedge clk);
                pre_ready = 1'b0;
                repeat ($urandom_range(3)) @(negedge clk);
                chk("R10 waiting for completion", longint'(pre_valid || plan_valid), 0);
                pre_done = 1'b1;
                @(negedge clk);
                pre_done = 1'b0;
                wait_cyc++;
            end else begin
                @(negedge clk);
                wait_cyc++;
            end
        end
        if (!got) chk("R11 plan issued", 0, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", longint'(req_ready), 1);
        chk("R1 no pre-read after reset", longint'(pre_valid), 0);
        chk("R1 no plan after reset", longint'(plan_valid), 0);

        run_req(64'h0000_4000, 1024, 0);      // aligned read
        run_req(64'h0000_41FF, 2, 0);         // read, head 511 and pad 511
        run_req(64'h0000_1010, 16, 1);        // write within one sector
        run_req(64'h0000_2005, 1500, 1);      // write, two edge sectors
        run_req(64'h0000_2005, 507, 1);       // write, head only
        run_req(64'h0000_3000, 700, 1);       // write, tail only
        run_req(64'h0000_3000, 512, 1);       // aligned write
        run_req(64'h0000_1234, 0, 1);         // zero-length write
        run_req(64'h0000_1234, 0, 0);         // zero-length read
        run_req(64'h0000_0001, (1 << LEN_W) - 1, 1); // maximum length
        run_req(64'h7FFF_FE00, 513, 1);       // high offset

        for (int i = 0; i < 80; i++) begin
            longint o, l;
            o = longint'($urandom() & 32'h7FFF_FFFF);
            case ($urandom_range(3))
                0:       l = longint'($urandom_range(511));
                1:       l = longint'($urandom_range(4096));
                default: l = longint'($urandom() & ((1 << LEN_W) - 1));
            endcase
            run_req(o, l, 1'($urandom_range(1)));
        end
        finish_run();
    end

endmodule